// File: doc/BRIEF.md
# Two-Stage Bark/Bite Watchdog Timer

This block is a watchdog with two countdown stages run one after the other. A prescaler turns the system clock into a one-second tick. After the watchdog is started, the first stage counts its programmed number of seconds. When that stage runs out, the block raises a bark condition, which shows as a status bit and as a level interrupt. The second stage then counts its own programmed number of seconds. When it runs out, the block requests a system reset of the type that software has selected. Software keeps the system alive by writing a pet bit. A pet restarts both the seconds prescaler and the first stage, and it clears the bark.

All configuration goes through a byte-wide register bus. Writes are single-cycle strobes and reads are combinational. The stage-one register holds the total timeout minus the pretimeout, and the stage-two register holds the pretimeout, so the time from pet to reset equals the total timeout. A cause flag records that a watchdog reset has happened. Only the power-on reset clears it, so software can read it after the system reset that the watchdog itself triggered.

Top module: `bark_bite_wdt`

## Requirements
- R1: After reset the register reads are: stage-one timer (address 0) 32, stage-two timer (address 1) 0, reset kind (address 2) 7, control (address 3) 0x00, status (address 5) 0x00, cause (address 6) 0x00. With all outputs at 0 and no start, nothing ever barks.
- R2: A write of control (address 3) with bit 7 set, while the watchdog is stopped, starts it. Bark rises exactly S1 x CLK_HZ cycles after that write edge.
- R3: The reset request rises S2 x CLK_HZ cycles after bark, where S2 is the stage-two value. When S2 is 0, the reset request rises in the same cycle as bark.
- R4: While the watchdog is running, a write to the pet register (address 4) with bit 0 set clears bark and restarts the prescaler and stage one, so bark comes S1 full seconds after the pet. A pet write with bit 0 clear has no effect.
- R5: A control write with bit 7 clear stops both stages and clears bark. While stopped, no bark and no reset request occur. A new start counts from the beginning.
- R6: Status bit 0 (address 5) reads 1 exactly while bark is set, and the output bark_irq equals it.
- R7: When the reset request fires, wd_reset_type shows the reset kind that was programmed (1 warm, 4 shutdown, 7 hard). While no reset is requested it shows 0. Once raised, the request holds until rst_n.
- R8: Cause bit 0 (address 6) becomes 1 when a reset request fires. It survives rst_n and is cleared only by por_n.
- R9: A timer register written while the watchdog is running does not change the countdown in progress. The new value applies from the next pet or start.
- R10: A stage-one value of 0 behaves as 1 second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock at CLK_HZ |
| rst_n | input | 1 | Active-low system reset; clears everything except the cause flag |
| por_n | input | 1 | Active-low power-on reset; clears the cause flag |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for bus_addr |
| bark_irq | output | 1 | Level interrupt, high while bark is set |
| wd_reset_req | output | 1 | Reset request, held until rst_n |
| wd_reset_type | output | 3 | Kind of reset requested, 0 when idle |

## Verification
A wrong stage count or a prescaler that does not restart moves the bark or reset edge by at least one full second of cycles. The bench therefore checks each edge in the cycle before it is due and in the cycle it is due. A stale copy of the configuration shows up as the old timing after a pet. A cause flag cleared by the wrong reset shows up on the very next read after rst_n. A lost reset kind shows on wd_reset_type in the same cycle as the request.

// File: rtl/bbw_pkg.sv
package bbw_pkg;
   localparam int unsigned REG_AW = 3;

   localparam logic [REG_AW-1:0] REG_STG1  = 3'd0;
   localparam logic [REG_AW-1:0] REG_STG2  = 3'd1;
   localparam logic [REG_AW-1:0] REG_KIND  = 3'd2;
   localparam logic [REG_AW-1:0] REG_CTRL  = 3'd3;
   localparam logic [REG_AW-1:0] REG_PET   = 3'd4;
   localparam logic [REG_AW-1:0] REG_STAT  = 3'd5;
   localparam logic [REG_AW-1:0] REG_CAUSE = 3'd6;

   localparam logic [2:0] KIND_WARM     = 3'd1;
   localparam logic [2:0] KIND_SHUTDOWN = 3'd4;
   localparam logic [2:0] KIND_HARD     = 3'd7;

   localparam int unsigned CTRL_RUN_BIT = 7;
   localparam int unsigned PET_BIT      = 0;

   typedef enum logic [1:0] {
      PH_IDLE,
      PH_BARK_WAIT,
      PH_BITE_WAIT,
      PH_FIRED
   } phase_e;
endpackage

// File: rtl/bbw_tick.sv
module bbw_tick #(
   parameter int unsigned CLK_HZ = 32768
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic run,
   output logic tick
);
   localparam int unsigned CW   = $clog2(CLK_HZ);
   localparam bit          POW2 = ((1 << CW) == CLK_HZ);

   logic [CW-1:0] cnt_q;

   generate
      if (POW2) begin : g_wrap
         assign tick = run && (&cnt_q);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   cnt_q <= '0;
            else if (clr) cnt_q <= '0;
            else if (run) cnt_q <= cnt_q + 1'b1;
         end
      end else begin : g_term
         localparam logic [CW-1:0] LAST = CW'(CLK_HZ - 1);
         assign tick = run && (cnt_q == LAST);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   cnt_q <= '0;
            else if (clr) cnt_q <= '0;
            else if (run) cnt_q <= tick ? '0 : cnt_q + 1'b1;
         end
      end
   endgenerate

   AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick); // R2
endmodule

// File: rtl/bbw_stages.sv
module bbw_stages
   import bbw_pkg::*;
#(
   parameter int unsigned TW = 7
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          pet,
   input  logic          stop,
   input  logic          tick,
   input  logic [TW-1:0] s1_cfg,
   input  logic [TW-1:0] s2_cfg,
   input  logic [2:0]    kind_cfg,
   output logic          run,
   output logic          bark,
   output logic          fire,
   output logic [2:0]    kind
);
   localparam logic [TW-1:0] ONE = TW'(1);

   phase_e        phase_q;
   logic [TW-1:0] cnt_q;
   logic [TW-1:0] s2_hold_q;
   logic          bark_q;
   logic [2:0]    kind_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q   <= PH_IDLE;
         cnt_q     <= '0;
         s2_hold_q <= '0;
         bark_q    <= 1'b0;
         kind_q    <= '0;
      end else if (phase_q != PH_FIRED) begin
         if (stop) begin
            phase_q <= PH_IDLE;
            bark_q  <= 1'b0;
         end else if (start || pet) begin
            phase_q   <= PH_BARK_WAIT;
            cnt_q     <= s1_cfg;
            s2_hold_q <= s2_cfg;
            bark_q    <= 1'b0;
         end else if (tick) begin
            if (phase_q == PH_BARK_WAIT) begin
               if (cnt_q <= ONE) begin
                  bark_q <= 1'b1;
                  if (s2_hold_q == '0) begin
                     phase_q <= PH_FIRED;
                     kind_q  <= kind_cfg;
                  end else begin
                     phase_q <= PH_BITE_WAIT;
                     cnt_q   <= s2_hold_q;
                  end
               end else begin
                  cnt_q <= cnt_q - ONE;
               end
            end else if (phase_q == PH_BITE_WAIT) begin
               if (cnt_q <= ONE) begin
                  phase_q <= PH_FIRED;
                  kind_q  <= kind_cfg;
               end else begin
                  cnt_q <= cnt_q - ONE;
               end
            end
         end
      end
   end

   assign run  = (phase_q == PH_BARK_WAIT) || (phase_q == PH_BITE_WAIT);
   assign bark = bark_q;
   assign fire = (phase_q == PH_FIRED);
   assign kind = kind_q;

   AST_BITE_AFTER_BARK: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fire) |-> bark); // R3
   AST_PET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (pet && !fire) |=> !bark); // R4
   AST_STOP_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
      (stop && !fire) |=> (!bark && !run)); // R5
   AST_FIRE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> fire); // R7
   AST_KIND_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !fire |-> (kind == 3'd0)); // R7
endmodule

// File: rtl/bbw_regs.sv
module bbw_regs
   import bbw_pkg::*;
#(
   parameter int unsigned TW          = 7,
   parameter int unsigned ADDR_W      = 3,
   parameter int unsigned DEF_TIMEOUT = 32,
   parameter int unsigned DEF_PRE     = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              por_n,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [7:0]        wdata,
   output logic [7:0]        rdata,
   input  logic              bark,
   input  logic              fire,
   output logic [TW-1:0]     s1_cfg,
   output logic [TW-1:0]     s2_cfg,
   output logic [2:0]        kind_cfg,
   output logic              start_p,
   output logic              pet_p,
   output logic              stop_p
);
   localparam logic [TW-1:0] S1_RST = TW'(DEF_TIMEOUT - DEF_PRE);
   localparam logic [TW-1:0] S2_RST = TW'(DEF_PRE);

   logic en_q;
   logic cause_q;
   logic hit_s1, hit_s2, hit_kind, hit_ctrl, hit_pet;

   assign hit_s1   = wr && (addr == ADDR_W'(REG_STG1));
   assign hit_s2   = wr && (addr == ADDR_W'(REG_STG2));
   assign hit_kind = wr && (addr == ADDR_W'(REG_KIND));
   assign hit_ctrl = wr && (addr == ADDR_W'(REG_CTRL));
   assign hit_pet  = wr && (addr == ADDR_W'(REG_PET));

   assign start_p = hit_ctrl &&  wdata[CTRL_RUN_BIT] && !en_q;
   assign stop_p  = hit_ctrl && !wdata[CTRL_RUN_BIT];
   assign pet_p   = hit_pet  &&  wdata[PET_BIT] && en_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_cfg   <= S1_RST;
         s2_cfg   <= S2_RST;
         kind_cfg <= KIND_HARD;
         en_q     <= 1'b0;
      end else begin
         if (hit_s1)   s1_cfg   <= wdata[TW-1:0];
         if (hit_s2)   s2_cfg   <= wdata[TW-1:0];
         if (hit_kind) kind_cfg <= wdata[2:0];
         if (hit_ctrl) en_q     <= wdata[CTRL_RUN_BIT];
      end
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)    cause_q <= 1'b0;
      else if (fire) cause_q <= 1'b1;
   end

   always_comb begin
      rdata = 8'h00;
      unique case (addr)
         ADDR_W'(REG_STG1):  rdata = 8'(s1_cfg);
         ADDR_W'(REG_STG2):  rdata = 8'(s2_cfg);
         ADDR_W'(REG_KIND):  rdata = {5'b0, kind_cfg};
         ADDR_W'(REG_CTRL):  rdata = {en_q, 7'b0};
         ADDR_W'(REG_STAT):  rdata = {7'b0, bark};
         ADDR_W'(REG_CAUSE): rdata = {7'b0, cause_q};
         default:            rdata = 8'h00;
      endcase
   end

   AST_CAUSE_SET: assert property (@(posedge clk) disable iff (!por_n)
      fire |=> cause_q); // R8
   AST_CAUSE_STICKY: assert property (@(posedge clk) disable iff (!por_n)
      cause_q |=> cause_q); // R8
endmodule

// File: rtl/bark_bite_wdt.sv
module bark_bite_wdt
   import bbw_pkg::*;
#(
   parameter int unsigned CLK_HZ      = 32768,
   parameter int unsigned TW          = 7,
   parameter int unsigned ADDR_W      = 3,
   parameter int unsigned DEF_TIMEOUT = 32,
   parameter int unsigned DEF_PRE     = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              por_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   output logic              bark_irq,
   output logic              wd_reset_req,
   output logic [2:0]        wd_reset_type
);
   initial begin
      assert (CLK_HZ >= 2) else $error("CLK_HZ must be at least 2");
      assert (TW >= 1 && TW <= 8) else $error("TW must be 1..8");
      assert (ADDR_W >= REG_AW) else $error("ADDR_W too narrow");
      assert (DEF_TIMEOUT >= 1 && DEF_TIMEOUT < (1 << TW))
         else $error("DEF_TIMEOUT out of range");
      assert (DEF_PRE <= DEF_TIMEOUT) else $error("DEF_PRE exceeds DEF_TIMEOUT");
   end

   logic [TW-1:0] s1_cfg, s2_cfg;
   logic [2:0]    kind_cfg;
   logic          start_p, pet_p, stop_p;
   logic          run, tick, bark, fire;

   bbw_regs #(
      .TW(TW), .ADDR_W(ADDR_W), .DEF_TIMEOUT(DEF_TIMEOUT), .DEF_PRE(DEF_PRE)
   ) regs_i (
      .clk(clk), .rst_n(rst_n), .por_n(por_n),
      .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata), .rdata(bus_rdata),
      .bark(bark), .fire(fire),
      .s1_cfg(s1_cfg), .s2_cfg(s2_cfg), .kind_cfg(kind_cfg),
      .start_p(start_p), .pet_p(pet_p), .stop_p(stop_p)
   );

   bbw_tick #(.CLK_HZ(CLK_HZ)) tick_i (
      .clk(clk), .rst_n(rst_n), .clr(start_p || pet_p), .run(run), .tick(tick)
   );

   bbw_stages #(.TW(TW)) stages_i (
      .clk(clk), .rst_n(rst_n),
      .start(start_p), .pet(pet_p), .stop(stop_p), .tick(tick),
      .s1_cfg(s1_cfg), .s2_cfg(s2_cfg), .kind_cfg(kind_cfg),
      .run(run), .bark(bark), .fire(fire), .kind(wd_reset_type)
   );

   assign bark_irq     = bark;
   assign wd_reset_req = fire;

   AST_NO_TICK_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
      !run |-> !tick); // R5
endmodule

// File: tb/bark_bite_wdt_tb_top.sv
module bark_bite_wdt_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int HZ = 4;

   localparam logic [2:0] A_S1 = 3'd0, A_S2 = 3'd1, A_KIND = 3'd2, A_CTRL = 3'd3,
                          A_PET = 3'd4, A_STAT = 3'd5, A_CAUSE = 3'd6;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       por_n = 1'b0;
   logic       bus_wr = 1'b0;
   logic [2:0] bus_addr = 3'd0;
   logic [7:0] bus_wdata = 8'h00;
   logic [7:0] bus_rdata;
   logic       bark_irq, wd_reset_req;
   logic [2:0] wd_reset_type;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   bark_bite_wdt #(.CLK_HZ(HZ)) dut_i (
      .clk(clk), .rst_n(rst_n), .por_n(por_n),
      .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .bark_irq(bark_irq),
      .wd_reset_req(wd_reset_req), .wd_reset_type(wd_reset_type)
   );

   function automatic int bark_cycles(int s1);
      return ((s1 == 0) ? 1 : s1) * HZ;
   endfunction

   function automatic int bite_cycles(int s2);
      return s2 * HZ;
   endfunction

   task automatic chk(string tag, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic wr(logic [2:0] a, logic [7:0] d);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd_chk(string tag, logic [2:0] a, int exp);
      bus_addr = a;
      #1;
      chk(tag, int'(bus_rdata), exp);
   endtask

   task automatic sys_reset();
      rst_n = 1'b0;
      idle(2);
      rst_n = 1'b1;
      idle(1);
   endtask

   task automatic trial(int s1, int s2, logic [2:0] ty, int pet_at);
      int tb;
      sys_reset();
      wr(A_S1, 8'(s1));
      wr(A_S2, 8'(s2));
      wr(A_KIND, {5'b0, ty});
      wr(A_CTRL, 8'h80);
      if (pet_at > 0) begin
         idle(pet_at - 1);
         chk("R4 bark before pet", int'(bark_irq), 0);
         wr(A_PET, 8'h01);
      end
      tb = bark_cycles(s1);          // R10 covers s1 == 0
      idle(tb - 1);
      chk("R2 bark early", int'(bark_irq), 0);
      idle(1);
      chk("R2 bark due", int'(bark_irq), 1);
      rd_chk("R6 status", A_STAT, 1);
      if (s2 == 0) begin
         chk("R3 bite with bark", int'(wd_reset_req), 1);
      end else begin
         chk("R3 bite not yet", int'(wd_reset_req), 0);
         idle(bite_cycles(s2) - 1);
         chk("R3 bite early", int'(wd_reset_req), 0);
         idle(1);
         chk("R3 bite due", int'(wd_reset_req), 1);
      end
      chk("R7 kind", int'(wd_reset_type), int'(ty));
      idle(3);
      chk("R7 held", int'(wd_reset_req), 1);
      rd_chk("R8 cause", A_CAUSE, 1);
   endtask

   initial begin
      logic [2:0] kinds [3];
      kinds[0] = 3'd1; kinds[1] = 3'd4; kinds[2] = 3'd7;
      void'($urandom(32'd20240611));

      idle(2);
      por_n = 1'b1;
      rst_n = 1'b1;
      idle(1);

      // R1 reset state
      rd_chk("R1 stage1", A_S1, 32);
      rd_chk("R1 stage2", A_S2, 0);
      rd_chk("R1 kind", A_KIND, 7);
      rd_chk("R1 ctrl", A_CTRL, 0);
      rd_chk("R1 status", A_STAT, 0);
      rd_chk("R1 cause", A_CAUSE, 0);
      chk("R1 irq", int'(bark_irq), 0);
      chk("R1 req", int'(wd_reset_req), 0);
      chk("R1 type", int'(wd_reset_type), 0);
      idle(300);
      chk("R1 no bark unstarted", int'(bark_irq), 0);

      // R4 pet with bit 0 clear is ignored
      wr(A_S1, 8'd2); wr(A_S2, 8'd1);
      wr(A_CTRL, 8'h80);
      idle(2);
      wr(A_PET, 8'hFE);
      idle(bark_cycles(2) - 3 - 1);
      chk("R4 ignored pet early", int'(bark_irq), 0);
      idle(1);
      chk("R4 ignored pet due", int'(bark_irq), 1);

      // R5 stop clears bark and halts both stages
      sys_reset();
      wr(A_S1, 8'd1); wr(A_S2, 8'd3);
      wr(A_CTRL, 8'h80);
      idle(HZ - 1);
      chk("R5 bark early", int'(bark_irq), 0);
      idle(1);
      chk("R5 bark due", int'(bark_irq), 1);
      wr(A_CTRL, 8'h00);
      chk("R5 stop clears bark", int'(bark_irq), 0);
      rd_chk("R5 ctrl read", A_CTRL, 0);
      idle(40);
      chk("R5 no bite stopped", int'(wd_reset_req), 0);
      chk("R5 no bark stopped", int'(bark_irq), 0);
      wr(A_CTRL, 8'h80);
      idle(HZ - 1);
      chk("R5 restart early", int'(bark_irq), 0);
      idle(1);
      chk("R5 restart due", int'(bark_irq), 1);

      // R9 timer writes while running are deferred
      sys_reset();
      wr(A_S1, 8'd3); wr(A_S2, 8'd5);
      wr(A_CTRL, 8'h80);
      wr(A_S1, 8'd1);
      idle(bark_cycles(3) - 2);
      chk("R9 old timing early", int'(bark_irq), 0);
      idle(1);
      chk("R9 old timing due", int'(bark_irq), 1);
      wr(A_PET, 8'h01);
      chk("R4 pet clears bark", int'(bark_irq), 0);
      idle(bark_cycles(1) - 1);
      chk("R9 new timing early", int'(bark_irq), 0);
      idle(1);
      chk("R9 new timing due", int'(bark_irq), 1);

      // random trials
      for (int t = 0; t < 24; t++) begin
         int s1, s2, pa;
         s1 = $urandom_range(0, 6);
         s2 = $urandom_range(0, 3);
         pa = ($urandom_range(0, 1) == 1) ? $urandom_range(1, bark_cycles(s1) - 1) : 0;
         trial(s1, s2, kinds[$urandom_range(0, 2)], pa);
      end

      // R8 cause survives rst_n and clears on por_n
      sys_reset();
      rd_chk("R8 survives rst_n", A_CAUSE, 1);
      chk("R7 req cleared by rst_n", int'(wd_reset_req), 0);
      chk("R7 type idle", int'(wd_reset_type), 0);
      por_n = 1'b0;
      idle(1);
      por_n = 1'b1;
      idle(1);
      rd_chk("R8 cleared by por_n", A_CAUSE, 0);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule